// File: doc/BRIEF.md
# Accumulator Execute Unit with Status Flags

This block is the execute stage of a small 8-bit accumulator processor. Each cycle it may accept one 14-bit instruction word together with the value already read from the addressed data register, the current accumulator and the current carry, digit-carry and zero flags. It decodes the opcode, performs the arithmetic, logic, rotate, swap, clear or move operation, and one clock later presents the 8-bit result, a write strobe for either the accumulator or the addressed register, and the three updated flags.

Each opcode owns a fixed subset of the flags. A flag that the opcode does not own is handed through unchanged from its input, so the surrounding pipeline can always write all three flags back. Register storage, program sequencing and skip handling live outside this block.

Top module: `alu_exec`

## Requirements
- R1: Results are registered: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and during reset `out_valid`, `wr_acc` and `wr_reg` are low.
- R2: Add (instr[13:8] = 010101) yields register + accumulator; C = carry out of bit 7, DC = carry out of bit 3, Z updated.
- R3: Subtract (instr[13:8] = 011010) yields register − accumulator; C = 1 when no borrow occurs, DC = 1 when the low nibble does not borrow, Z updated.
- R4: For register-source opcodes, instr[7] selects the destination: 0 writes the accumulator (`wr_acc`), 1 writes the register whose address is instr[6:0] (`reg_addr`); at most one of the two strobes is ever high.
- R5: Rotate right (011110) yields {C_in, r[7:1]} with C = r[0]; rotate left (011100) yields {r[6:0], C_in} with C = r[7]; neither changes DC or Z.
- R6: Nibble swap (011101) yields {r[3:0], r[7:4]} and leaves all three flags equal to their inputs.
- R7: Increment (011000), decrement (010110) and complement (010010) yield r+1, r−1 and ~r and change only Z.
- R8: Register logic with the accumulator: AND (010100), OR (011111), XOR (011011), and move-register (010011, result r); each changes only Z.
- R9: Immediate forms take instr[7:0] as operand and always write the accumulator: AND (001001), XOR (001000), OR (000011) change only Z; move-immediate (000001) changes no flag.
- R10: Clear accumulator (01 0001 0000 0000) and clear register (01 0001 1rrrrrrr) give result 0 and set Z; store accumulator (01 0000 1rrrrrrr) writes the accumulator value to the register and changes no flag.
- R11: Whenever an opcode owns Z, Z out is 1 exactly when the 8-bit result is zero; every flag an opcode does not own equals its input.
- R12: Any other encoding (including instr[13:12] = 11, 010111, 011001, 01 0001 0 with nonzero low bits, 01 0000 0xxxxxxx) raises neither write strobe and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 14 | Instruction word |
| reg_val | input | 8 | Value of the addressed data register |
| acc_val | input | 8 | Current accumulator |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result fields are valid |
| result | output | 8 | Operation result |
| wr_acc | output | 1 | Write result to the accumulator |
| wr_reg | output | 1 | Write result to the addressed register |
| reg_addr | output | 7 | Address of the register to write |
| c_out | output | 1 | Updated carry flag |
| dc_out | output | 1 | Updated digit-carry flag |
| z_out | output | 1 | Updated zero flag |

## Verification
The two functions that share every cycle are flag generation for the owned flags and pass-through of the unowned ones, and for rotates the carry is both consumed and produced by the same operation. The bench provokes this by presenting incoming flags opposite to what the opcode would compute (all set for swap and move-immediate, carry set for rotates of values whose shifted-out bit is zero, and so on) and by streaming instructions back to back. A scoreboard model derived from the requirements judges each flag separately against either its newly computed value or its incoming value.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   typedef enum logic [4:0] {
      OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_MOVR,
      OP_INC, OP_DEC, OP_COM, OP_RR, OP_RL, OP_SWAP,
      OP_ANDI, OP_XORI, OP_IORI, OP_MOVI, OP_CLRA, OP_CLRR, OP_MOVAR
   } alu_op_e;

   // opcode field instr[13:8]
   localparam logic [5:0] OPC_ADD   = 6'b010101;
   localparam logic [5:0] OPC_SUB   = 6'b011010;
   localparam logic [5:0] OPC_AND   = 6'b010100;
   localparam logic [5:0] OPC_IOR   = 6'b011111;
   localparam logic [5:0] OPC_XOR   = 6'b011011;
   localparam logic [5:0] OPC_MOVR  = 6'b010011;
   localparam logic [5:0] OPC_INC   = 6'b011000;
   localparam logic [5:0] OPC_DEC   = 6'b010110;
   localparam logic [5:0] OPC_COM   = 6'b010010;
   localparam logic [5:0] OPC_RR    = 6'b011110;
   localparam logic [5:0] OPC_RL    = 6'b011100;
   localparam logic [5:0] OPC_SWAP  = 6'b011101;
   localparam logic [5:0] OPC_ANDI  = 6'b001001;
   localparam logic [5:0] OPC_XORI  = 6'b001000;
   localparam logic [5:0] OPC_IORI  = 6'b000011;
   localparam logic [5:0] OPC_MOVI  = 6'b000001;
   localparam logic [5:0] OPC_CLR   = 6'b010001;
   localparam logic [5:0] OPC_STORE = 6'b010000;

   localparam int FLAG_C  = 0;
   localparam int FLAG_DC = 1;
   localparam int FLAG_Z  = 2;
   localparam int NFLAGS  = 3;

   typedef struct packed {
      alu_op_e           op;
      logic              to_acc;
      logic              to_reg;
      logic [NFLAGS-1:0] fmask;
   } alu_dec_t;

   // which flags each operation is allowed to change
   function automatic logic [NFLAGS-1:0] flag_owner(alu_op_e op);
      logic [NFLAGS-1:0] m;
      m = '0;
      unique case (op)
         OP_ADD, OP_SUB:                        m = 3'b111;
         OP_RR, OP_RL:                          m = 3'b001;
         OP_AND, OP_IOR, OP_XOR, OP_MOVR,
         OP_INC, OP_DEC, OP_COM,
         OP_ANDI, OP_XORI, OP_IORI,
         OP_CLRA, OP_CLRR:                      m = 3'b100;
         default:                               m = 3'b000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
   import alu_exec_pkg::*;
#(
   parameter int INSTR_W = 14,
   parameter int ADDR_W  = 7
) (
   input  logic [INSTR_W-1:0] instr,
   output alu_dec_t           dec
);
   localparam int OPC_LSB = INSTR_W - 6;
   localparam int DST_BIT = ADDR_W;

   if (INSTR_W != 14) begin : g_bad_instr_w
      $error("alu_exec_decode: INSTR_W must be 14");
   end
   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("alu_exec_decode: ADDR_W must be 7");
   end

   logic [5:0]        opc;
   logic              dst;
   logic [ADDR_W-1:0] low;

   assign opc = instr[INSTR_W-1:OPC_LSB];
   assign dst = instr[DST_BIT];
   assign low = instr[ADDR_W-1:0];

   always_comb begin
      dec        = '0;
      dec.op     = OP_NONE;
      unique case (opc)
         OPC_ADD:  dec.op = OP_ADD;
         OPC_SUB:  dec.op = OP_SUB;
         OPC_AND:  dec.op = OP_AND;
         OPC_IOR:  dec.op = OP_IOR;
         OPC_XOR:  dec.op = OP_XOR;
         OPC_MOVR: dec.op = OP_MOVR;
         OPC_INC:  dec.op = OP_INC;
         OPC_DEC:  dec.op = OP_DEC;
         OPC_COM:  dec.op = OP_COM;
         OPC_RR:   dec.op = OP_RR;
         OPC_RL:   dec.op = OP_RL;
         OPC_SWAP: dec.op = OP_SWAP;
         OPC_ANDI: dec.op = OP_ANDI;
         OPC_XORI: dec.op = OP_XORI;
         OPC_IORI: dec.op = OP_IORI;
         OPC_MOVI: dec.op = OP_MOVI;
         OPC_CLR: begin
            if (dst)             dec.op = OP_CLRR;
            else if (low == '0)  dec.op = OP_CLRA;
            else                 dec.op = OP_NONE;
         end
         OPC_STORE: dec.op = dst ? OP_MOVAR : OP_NONE;
         default:   dec.op = OP_NONE;
      endcase

      unique case (dec.op)
         OP_NONE: begin
            dec.to_acc = 1'b0;
            dec.to_reg = 1'b0;
         end
         OP_ANDI, OP_XORI, OP_IORI, OP_MOVI, OP_CLRA: begin
            dec.to_acc = 1'b1;
            dec.to_reg = 1'b0;
         end
         OP_CLRR, OP_MOVAR: begin
            dec.to_acc = 1'b0;
            dec.to_reg = 1'b1;
         end
         default: begin
            dec.to_acc = ~dst;
            dec.to_reg = dst;
         end
      endcase
      dec.fmask = flag_owner(dec.op);
   end

endmodule

// File: rtl/alu_exec_arith.sv
module alu_exec_arith
   import alu_exec_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit CARRY_SPLIT = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opr,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] imm,
   input  logic              c_in,
   output logic [DATA_W-1:0] result,
   output logic              c_new,
   output logic              dc_new
);
   localparam int NIB  = 4;
   localparam int HI_W = DATA_W - NIB;
   localparam int HALF = DATA_W / 2;

   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_w
      $error("alu_exec_arith: DATA_W must be even and at least 8");
   end

   logic [DATA_W-1:0] add_x, add_y, sum;
   logic              add_ci, cout, dcout;

   // operand steering for the shared adder
   always_comb begin
      add_x  = opr;
      add_y  = acc;
      add_ci = 1'b0;
      unique case (op)
         OP_SUB: begin add_y = ~acc;           add_ci = 1'b1; end
         OP_INC: begin add_y = '0;             add_ci = 1'b1; end
         OP_DEC: begin add_y = {DATA_W{1'b1}}; add_ci = 1'b0; end
         default: begin add_y = acc;           add_ci = 1'b0; end
      endcase
   end

   logic [NIB:0] lo;
   assign lo = {1'b0, add_x[NIB-1:0]} + {1'b0, add_y[NIB-1:0]}
             + {{NIB{1'b0}}, add_ci};
   assign dcout = lo[NIB];

   if (CARRY_SPLIT) begin : g_split
      logic [HI_W:0] hi;
      assign hi   = {1'b0, add_x[DATA_W-1:NIB]} + {1'b0, add_y[DATA_W-1:NIB]}
                  + {{HI_W{1'b0}}, lo[NIB]};
      assign sum  = {hi[HI_W-1:0], lo[NIB-1:0]};
      assign cout = hi[HI_W];
   end else begin : g_flat
      logic [DATA_W:0] full;
      assign full = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};
      assign sum  = full[DATA_W-1:0];
      assign cout = full[DATA_W];
   end

   always_comb begin
      result = '0;
      c_new  = c_in;
      unique case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            result = sum;
            c_new  = cout;
         end
         OP_AND:   result = opr & acc;
         OP_IOR:   result = opr | acc;
         OP_XOR:   result = opr ^ acc;
         OP_MOVR:  result = opr;
         OP_COM:   result = ~opr;
         OP_RR: begin
            result = {c_in, opr[DATA_W-1:1]};
            c_new  = opr[0];
         end
         OP_RL: begin
            result = {opr[DATA_W-2:0], c_in};
            c_new  = opr[DATA_W-1];
         end
         OP_SWAP:  result = {opr[HALF-1:0], opr[DATA_W-1:HALF]};
         OP_ANDI:  result = imm & acc;
         OP_XORI:  result = imm ^ acc;
         OP_IORI:  result = imm | acc;
         OP_MOVI:  result = imm;
         OP_MOVAR: result = acc;
         default:  result = '0;
      endcase
   end

   assign dc_new = dcout;

endmodule

// File: rtl/alu_exec_flags.sv
module alu_exec_flags
   import alu_exec_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [NFLAGS-1:0] fmask,
   input  logic [DATA_W-1:0] result,
   input  logic              c_new,
   input  logic              dc_new,
   input  logic              c_in,
   input  logic              dc_in,
   input  logic              z_in,
   output logic              c_out,
   output logic              dc_out,
   output logic              z_out
);
   logic [NFLAGS-1:0] fresh, prior, merged;

   always_comb begin
      fresh          = '0;
      fresh[FLAG_C]  = c_new;
      fresh[FLAG_DC] = dc_new;
      fresh[FLAG_Z]  = ~|result;
      prior          = '0;
      prior[FLAG_C]  = c_in;
      prior[FLAG_DC] = dc_in;
      prior[FLAG_Z]  = z_in;
   end

   for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
      assign merged[f] = fmask[f] ? fresh[f] : prior[f];
   end

   assign c_out  = merged[FLAG_C];
   assign dc_out = merged[FLAG_DC];
   assign z_out  = merged[FLAG_Z];

endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_exec_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int INSTR_W     = 14,
   parameter int ADDR_W      = 7,
   parameter bit CARRY_SPLIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  reg_val,
   input  logic [DATA_W-1:0]  acc_val,
   input  logic               c_in,
   input  logic               dc_in,
   input  logic               z_in,
   output logic               out_valid,
   output logic [DATA_W-1:0]  result,
   output logic               wr_acc,
   output logic               wr_reg,
   output logic [ADDR_W-1:0]  reg_addr,
   output logic               c_out,
   output logic               dc_out,
   output logic               z_out
);
   localparam int OPC_LSB = INSTR_W - 6;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("alu_exec: immediate field fixes DATA_W at 8");
   end

   alu_dec_t          dec;
   logic [DATA_W-1:0] res_d;
   logic              cn, dcn, c_d, dc_d, z_d;

   alu_exec_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   alu_exec_arith #(.DATA_W(DATA_W), .CARRY_SPLIT(CARRY_SPLIT)) u_arith (
      .op     (dec.op),
      .opr    (reg_val),
      .acc    (acc_val),
      .imm    (instr[DATA_W-1:0]),
      .c_in   (c_in),
      .result (res_d),
      .c_new  (cn),
      .dc_new (dcn)
   );

   alu_exec_flags #(.DATA_W(DATA_W)) u_flags (
      .fmask  (dec.fmask),
      .result (res_d),
      .c_new  (cn),
      .dc_new (dcn),
      .c_in   (c_in),
      .dc_in  (dc_in),
      .z_in   (z_in),
      .c_out  (c_d),
      .dc_out (dc_d),
      .z_out  (z_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_acc    <= 1'b0;
         wr_reg    <= 1'b0;
         result    <= '0;
         reg_addr  <= '0;
         c_out     <= 1'b0;
         dc_out    <= 1'b0;
         z_out     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_acc    <= in_valid & dec.to_acc;
         wr_reg    <= in_valid & dec.to_reg;
         if (in_valid) begin
            result   <= res_d;
            reg_addr <= instr[ADDR_W-1:0];
            c_out    <= c_d;
            dc_out   <= dc_d;
            z_out    <= z_d;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r4_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_acc, wr_reg}) <= 1);

   a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!wr_acc && !wr_reg));

   a_r5_rotate_keeps_dc_z: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (instr[INSTR_W-1:OPC_LSB] == OPC_RR ||
                    instr[INSTR_W-1:OPC_LSB] == OPC_RL))
      |=> (dc_out == $past(dc_in) && z_out == $past(z_in)));

   a_r6_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[INSTR_W-1:OPC_LSB] == OPC_SWAP)
      |=> (c_out == $past(c_in) && dc_out == $past(dc_in) && z_out == $past(z_in)));

   a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[INSTR_W-1:OPC_LSB] == OPC_CLR && instr[ADDR_W])
      |=> (result == '0 && z_out && wr_reg));

   a_r12_unlisted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[INSTR_W-1:INSTR_W-2] == 2'b11)
      |=> (!wr_acc && !wr_reg && c_out == $past(c_in)
           && dc_out == $past(dc_in) && z_out == $past(z_in)));

endmodule

// File: tb/tb_alu_exec.sv
module tb_alu_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] instr = '0;
   logic [7:0]  reg_val = '0;
   logic [7:0]  acc_val = '0;
   logic        c_in = 1'b0, dc_in = 1'b0, z_in = 1'b0;
   logic        out_valid, wr_acc, wr_reg, c_out, dc_out, z_out;
   logic [7:0]  result;
   logic [6:0]  reg_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   alu_exec dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .reg_val(reg_val), .acc_val(acc_val), .c_in(c_in), .dc_in(dc_in),
      .z_in(z_in), .out_valid(out_valid), .result(result), .wr_acc(wr_acc),
      .wr_reg(wr_reg), .reg_addr(reg_addr), .c_out(c_out), .dc_out(dc_out),
      .z_out(z_out)
   );

   typedef struct {
      logic       wacc, wreg;
      logic [7:0] res;
      logic [6:0] addr;
      logic       c, dc, z;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   function automatic exp_t model(logic [13:0] ins, logic [7:0] r, logic [7:0] a,
                                  logic c, logic dc, logic z, string tag);
      exp_t e;
      logic       d    = ins[7];
      logic [7:0] im   = ins[7:0];
      logic       upz  = 1'b0;
      logic       dform = 1'b0;
      logic [8:0] t;
      e.wacc = 0; e.wreg = 0; e.res = 8'h00; e.addr = ins[6:0];
      e.c = c; e.dc = dc; e.z = z; e.tag = tag;
      case (ins[13:8])
         6'b010101: begin
            t = {1'b0, r} + {1'b0, a};
            e.res = t[7:0]; e.c = t[8];
            e.dc = (int'(r[3:0]) + int'(a[3:0])) > 15;
            dform = 1; upz = 1;
         end
         6'b011010: begin
            e.res = r - a; e.c = (r >= a); e.dc = (r[3:0] >= a[3:0]);
            dform = 1; upz = 1;
         end
         6'b010100: begin e.res = r & a; dform = 1; upz = 1; end
         6'b011111: begin e.res = r | a; dform = 1; upz = 1; end
         6'b011011: begin e.res = r ^ a; dform = 1; upz = 1; end
         6'b010011: begin e.res = r;     dform = 1; upz = 1; end
         6'b011000: begin e.res = r + 8'd1; dform = 1; upz = 1; end
         6'b010110: begin e.res = r - 8'd1; dform = 1; upz = 1; end
         6'b010010: begin e.res = ~r;    dform = 1; upz = 1; end
         6'b011110: begin e.res = {c, r[7:1]}; e.c = r[0]; dform = 1; end
         6'b011100: begin e.res = {r[6:0], c}; e.c = r[7]; dform = 1; end
         6'b011101: begin e.res = {r[3:0], r[7:4]}; dform = 1; end
         6'b001001: begin e.res = im & a; e.wacc = 1; upz = 1; end
         6'b001000: begin e.res = im ^ a; e.wacc = 1; upz = 1; end
         6'b000011: begin e.res = im | a; e.wacc = 1; upz = 1; end
         6'b000001: begin e.res = im;     e.wacc = 1; end
         6'b010001: begin
            if (d) begin e.res = 0; e.wreg = 1; upz = 1; end
            else if (ins[6:0] == 0) begin e.res = 0; e.wacc = 1; upz = 1; end
         end
         6'b010000: begin
            if (d) begin e.res = a; e.wreg = 1; end
         end
         default: ;
      endcase
      if (dform) begin e.wacc = !d; e.wreg = d; end
      if (upz) e.z = (e.res == 8'h00);
      return e;
   endfunction

   task automatic issue(logic [13:0] ins, logic [7:0] r, logic [7:0] a,
                        logic c, logic dc, logic z, string tag);
      instr = ins; reg_val = r; acc_val = a; c_in = c; dc_in = dc; z_in = z;
      in_valid = 1'b1;
      exp_q.push_back(model(ins, r, a, c, dc, z, tag));
      @(negedge clk);
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1: out_valid without issued instruction (act 1 exp 0)");
         end else begin
            exp_t e;
            bit ok;
            e = exp_q.pop_front();
            ok = (wr_acc == e.wacc) && (wr_reg == e.wreg) && (c_out == e.c)
               && (dc_out == e.dc) && (z_out == e.z)
               && (!(e.wacc || e.wreg) || result == e.res)
               && (!e.wreg || reg_addr == e.addr);
            if (!ok) begin
               fails++;
               $display("FAIL %s: act wa=%0b wr=%0b res=%02h addr=%02h c=%0b dc=%0b z=%0b exp wa=%0b wr=%0b res=%02h addr=%02h c=%0b dc=%0b z=%0b",
                        e.tag, wr_acc, wr_reg, result, reg_addr, c_out, dc_out, z_out,
                        e.wacc, e.wreg, e.res, e.addr, e.c, e.dc, e.z);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: act hung exp finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [5:0]  ops[20];
      ops = '{6'b010101, 6'b011010, 6'b010100, 6'b011111, 6'b011011, 6'b010011,
              6'b011000, 6'b010110, 6'b010010, 6'b011110, 6'b011100, 6'b011101,
              6'b001001, 6'b001000, 6'b000011, 6'b000001, 6'b010001, 6'b010000,
              6'b010111, 6'b110110};
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (out_valid !== 1'b0 || wr_acc !== 1'b0 || wr_reg !== 1'b0) begin
         fails++;
         $display("FAIL R1: reset act v=%0b wa=%0b wr=%0b exp 0 0 0", out_valid, wr_acc, wr_reg);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2 add: nibble carry, full carry with zero, plain
      issue(14'b01_0101_0_0000000 | 14'h05, 8'h0F, 8'h01, 0, 0, 1, "R2");
      issue(14'b01_0101_0_0000000, 8'hFF, 8'h01, 0, 0, 0, "R2");
      issue(14'b01_0101_1_0010011, 8'h10, 8'h20, 1, 1, 1, "R2");
      // R3 subtract: no borrow, borrow, low-nibble borrow, equal
      issue(14'b01_1010_0_0000000, 8'h05, 8'h03, 0, 0, 1, "R3");
      issue(14'b01_1010_0_0000000, 8'h03, 8'h05, 1, 1, 1, "R3");
      issue(14'b01_1010_1_1111111, 8'h10, 8'h01, 0, 1, 1, "R3");
      issue(14'b01_1010_0_0000000, 8'h7A, 8'h7A, 0, 0, 0, "R3");
      // R4 destination select
      issue(14'b01_0011_1_1010101, 8'h42, 8'h00, 0, 0, 1, "R4");
      issue(14'b01_0011_0_1010101, 8'h42, 8'h00, 0, 0, 1, "R4");
      // R5 rotates through carry, flags opposite
      issue(14'b01_1110_0_0000000, 8'h80, 8'h00, 1, 1, 1, "R5");
      issue(14'b01_1110_1_0000001, 8'h01, 8'h00, 0, 0, 0, "R5");
      issue(14'b01_1100_0_0000000, 8'h80, 8'h00, 0, 1, 0, "R5");
      issue(14'b01_1100_0_0000000, 8'h01, 8'h00, 1, 0, 1, "R5");
      // R6 swap with all flags set and clear
      issue(14'b01_1101_0_0000000, 8'hA5, 8'h00, 1, 1, 1, "R6");
      issue(14'b01_1101_1_0000111, 8'h00, 8'h00, 0, 0, 0, "R6");
      // R7 inc, dec, com
      issue(14'b01_1000_0_0000000, 8'hFF, 8'h00, 1, 1, 0, "R7");
      issue(14'b01_0110_0_0000000, 8'h01, 8'h00, 0, 0, 0, "R7");
      issue(14'b01_0010_0_0000000, 8'hFF, 8'h00, 1, 0, 0, "R7");
      // R8 register logic
      issue(14'b01_0100_0_0000000, 8'hF0, 8'h0F, 1, 1, 0, "R8");
      issue(14'b01_1111_0_0000000, 8'hF0, 8'h0F, 0, 0, 1, "R8");
      issue(14'b01_1011_0_0000000, 8'h5A, 8'h5A, 0, 0, 0, "R8");
      // R9 immediates
      issue(14'b00_1001_00001111, 8'h00, 8'h3C, 1, 1, 1, "R9");
      issue(14'b00_1000_11111111, 8'h00, 8'hFF, 0, 0, 0, "R9");
      issue(14'b00_0011_00000000, 8'h00, 8'h00, 0, 0, 0, "R9");
      issue(14'b00_0001_00000000, 8'h77, 8'h77, 0, 1, 0, "R9");
      // R10 clears and store
      issue(14'b01_0001_0_0000000, 8'h33, 8'h33, 1, 1, 0, "R10");
      issue(14'b01_0001_1_0001000, 8'h33, 8'h33, 0, 0, 0, "R10");
      issue(14'b01_0000_1_0000100, 8'h00, 8'h9C, 1, 0, 1, "R10");
      // R12 unlisted encodings
      issue(14'h3FFF, 8'h00, 8'h00, 1, 0, 1, "R12");
      issue(14'b01_0111_0_0000000, 8'h01, 8'h00, 0, 1, 0, "R12");
      issue(14'b01_0001_0_0000001, 8'h01, 8'h01, 1, 1, 0, "R12");
      issue(14'b01_0000_0_0000000, 8'h01, 8'h01, 0, 0, 1, "R12");
      idle(2);

      // R11 sweep of pseudo-random operands over all opcodes, back to back
      lfsr = 16'hACE1;
      for (int i = 0; i < 240; i++) begin
         logic [13:0] ins;
         logic [7:0]  rv, av;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rv   = lfsr[7:0];
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         av   = (i % 7 == 0) ? rv : lfsr[15:8];
         ins  = {ops[i % 20], lfsr[7:0]};
         issue(ins, rv, av, lfsr[1], lfsr[2], lfsr[3], "R11");
         if (i % 37 == 36) idle(1);
      end
      idle(4);

      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1: results missing act %0d exp 0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule